// File: doc/BRIEF.md
# Colour Palette RAM with Host Access Sequencer

This block holds a 256-entry colour palette, each entry three 6-bit components (red, green, blue). A host fills and inspects the palette one component byte at a time through three byte-wide ports. One port loads the read index, one loads the write index, and one moves data. A shared component counter steps through red, green and blue. The matching entry index advances automatically after every third access, so a whole palette can be streamed with a single index load.

Host writes are gathered in a small holding buffer. They reach the palette only when the third component arrives, so the display never sees a half-updated colour. A separate lookup port, used by the display path, takes an entry number and returns the colour one cycle later as 24 bits. Each component is widened from 6 to 8 bits by copying its lowest bit into the two new low bits.

The lookup port is a pipe with no back-pressure. A request is taken on every cycle where `lk_valid` is high, and `lk_rvalid` marks the result in the following cycle. The host pins are plain strobes with no handshake.

Top module: `pal_dac_port`

## Requirements
- R1: After reset, the write index, read index, component counter and status code are 0. A host read of the write-index port (select 1) returns 0, a read of the read-index port (select 0) returns 0, and `lk_rvalid` is low.
- R2: A host write to select 1 loads the write index, clears the component counter and sets the status code to 0. A host read of select 1 returns the write index, and a read of select 0 returns the status code.
- R3: A host write to select 0 loads the read index, clears the component counter and sets the status code to 3.
- R4: Each host write to the data port (select 2) buffers the low 6 bits as component number counter (0 red, 1 green, 2 blue). On the third write, all three components are written into the entry at the write index together, the counter returns to 0 and the write index increments. An entry is unchanged after only one or two data writes.
- R5: Each host read of the data port returns, zero-extended, component number counter of the entry at the read index. After the third component, the counter returns to 0 and the read index increments.
- R6: Both indices are 8 bits and wrap from 255 to 0.
- R7: Data reads and data writes share one component counter, so a read that follows a partial write continues from the write's counter value.
- R8: Loading the write index in the middle of a triple discards the buffered components. The next three data writes then form a complete new entry.
- R9: Each 6-bit component v widens to 8 bits as {v, v[0], v[0]}.
- R10: When `lk_valid` is high, the next cycle shows `lk_rvalid` high and `lk_rgb` holding red in bits 23:16, green in 15:8 and blue in 7:0. Otherwise `lk_rvalid` is low in the next cycle.
- R11: When `hst_wr` and `hst_rd` are both high, only the write acts and the read has no side effect. Select 3 is unused: writes to it are ignored and reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_wr | input | 1 | Host write strobe |
| hst_rd | input | 1 | Host read strobe |
| hst_sel | input | 2 | Port select: 0 read index/status, 1 write index, 2 data, 3 unused |
| hst_wdata | input | 8 | Host write byte |
| hst_rdata | output | 8 | Host read byte, valid in the cycle of the strobe |
| lk_valid | input | 1 | Lookup request |
| lk_idx | input | 8 | Lookup entry number |
| lk_rvalid | output | 1 | Lookup result valid, one cycle after the request |
| lk_rgb | output | 24 | Widened colour of the looked-up entry |

## Verification
The bench builds the block with its default parameters: 8-bit indices, 6-bit components and 8-bit outputs. Index wrap is therefore reached with one index load of 255 followed by a single triple. Component values 0x3F, 0x01, 0x20 and 0x21 cover both polarities of the copied low bit and the extremes of the widening. Interleaving partial writes with reads exposes the shared counter, and reloading the write index mid-triple shows that buffered bytes are discarded.

// File: rtl/pal_dac_pkg.sv
package pal_dac_pkg;
  typedef enum logic [1:0] {
    SEL_RDIDX = 2'd0,
    SEL_WRIDX = 2'd1,
    SEL_DATA  = 2'd2,
    SEL_NONE  = 2'd3
  } hsel_e;

  localparam int unsigned NCOMP = 3;
  localparam logic [1:0] ST_WRITING = 2'd0;
  localparam logic [1:0] ST_READING = 2'd3;
endpackage

// File: rtl/pal_dac_widen.sv
module pal_dac_widen #(
  parameter int unsigned CW = 6,
  parameter int unsigned OW = 8
) (
  input  logic [CW-1:0] comp_i,
  output logic [OW-1:0] comp_o
);
  localparam int unsigned PAD = OW - CW;
  // the low bit fills every added position
  assign comp_o = {comp_i, {PAD{comp_i[0]}}};
endmodule

// File: rtl/pal_dac_seq.sv
module pal_dac_seq
  import pal_dac_pkg::*;
#(
  parameter int unsigned IW = 8,
  parameter int unsigned CW = 6,
  parameter int unsigned DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_wr,
  input  logic              hst_rd,
  input  logic [1:0]        hst_sel,
  input  logic [DW-1:0]     hst_wdata,
  output logic [DW-1:0]     hst_rdata,
  input  logic [3*CW-1:0]   rd_word,
  output logic [IW-1:0]     rd_idx,
  output logic              ram_we,
  output logic [IW-1:0]     ram_waddr,
  output logic [3*CW-1:0]   ram_wdata
);
  localparam int unsigned WORDW = NCOMP * CW;

  logic [IW-1:0] rd_idx_q, wr_idx_q;
  logic [1:0]    sub_q;
  logic [1:0]    state_q;
  logic [CW-1:0] cache_q [2];
  logic          rd_act, wr_data, rd_data, last_comp;
  logic [CW-1:0] comp_sel;

  assign rd_act    = hst_rd && !hst_wr;
  assign wr_data   = hst_wr && (hst_sel == SEL_DATA);
  assign rd_data   = rd_act && (hst_sel == SEL_DATA);
  assign last_comp = (sub_q == 2'd2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_idx_q   <= '0;
      wr_idx_q   <= '0;
      sub_q      <= '0;
      state_q    <= ST_WRITING;
      cache_q[0] <= '0;
      cache_q[1] <= '0;
    end else if (hst_wr) begin
      case (hst_sel)
        SEL_RDIDX: begin
          rd_idx_q <= hst_wdata[IW-1:0];
          sub_q    <= '0;
          state_q  <= ST_READING;
        end
        SEL_WRIDX: begin
          wr_idx_q <= hst_wdata[IW-1:0];
          sub_q    <= '0;
          state_q  <= ST_WRITING;
        end
        SEL_DATA: begin
          if (last_comp) begin
            sub_q    <= '0;
            wr_idx_q <= wr_idx_q + 1'b1;
          end else begin
            cache_q[sub_q[0]] <= hst_wdata[CW-1:0];
            sub_q             <= sub_q + 1'b1;
          end
        end
        default: ;
      endcase
    end else if (rd_data) begin
      if (last_comp) begin
        sub_q    <= '0;
        rd_idx_q <= rd_idx_q + 1'b1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  assign ram_we    = wr_data && last_comp;
  assign ram_waddr = wr_idx_q;
  assign ram_wdata = {cache_q[0], cache_q[1], hst_wdata[CW-1:0]};
  assign rd_idx    = rd_idx_q;

  always_comb begin
    case (sub_q)
      2'd0:    comp_sel = rd_word[WORDW-1 -: CW];
      2'd1:    comp_sel = rd_word[WORDW-CW-1 -: CW];
      default: comp_sel = rd_word[CW-1:0];
    endcase
  end

  always_comb begin
    hst_rdata = '0;
    case (hst_sel)
      SEL_RDIDX: hst_rdata = DW'(state_q);
      SEL_WRIDX: hst_rdata = DW'(wr_idx_q);
      SEL_DATA:  hst_rdata = DW'(comp_sel);
      default:   hst_rdata = '0;
    endcase
  end

  // R4/R5/R7: shared counter never leaves 0..2
  a_r7_sub_range: assert property (@(posedge clk) disable iff (!rst_n)
    sub_q != 2'd3);
  // R2/R3: status code is one of the two defined values
  a_r3_state_code: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WRITING) || (state_q == ST_READING));
  // R2: write-index load clears counter and status
  a_r2_wridx_load: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_wr && hst_sel == SEL_WRIDX) |=> (sub_q == 2'd0 && state_q == ST_WRITING));
  // R4: commit advances write index
  a_r4_commit_adv: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> (wr_idx_q == IW'($past(wr_idx_q) + 1'b1)));
  // R5: third read advances read index
  a_r5_read_adv: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && last_comp) |=> (rd_idx_q == IW'($past(rd_idx_q) + 1'b1)));
  // R11: unused select leaves indices alone
  a_r11_none_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_wr && hst_sel == SEL_NONE) |=> ($stable(wr_idx_q) && $stable(rd_idx_q)));
endmodule

// File: rtl/pal_dac_ram.sv
module pal_dac_ram
  import pal_dac_pkg::*;
#(
  parameter int unsigned IW = 8,
  parameter int unsigned CW = 6,
  parameter int unsigned OW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [IW-1:0]       waddr,
  input  logic [3*CW-1:0]     wdata,
  input  logic [IW-1:0]       raddr,
  output logic [3*CW-1:0]     rword,
  input  logic                lk_valid,
  input  logic [IW-1:0]       lk_idx,
  output logic                lk_rvalid,
  output logic [3*OW-1:0]     lk_rgb
);
  localparam int unsigned DEPTH = 1 << IW;
  localparam int unsigned WORDW = NCOMP * CW;

  logic [WORDW-1:0] mem [DEPTH];
  logic [WORDW-1:0] lk_word_q;
  logic             lk_rvalid_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rword = mem[raddr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_rvalid_q <= 1'b0;
      lk_word_q   <= '0;
    end else begin
      lk_rvalid_q <= lk_valid;
      if (lk_valid) lk_word_q <= mem[lk_idx];
    end
  end

  assign lk_rvalid = lk_rvalid_q;

  // component 0 (red) sits highest in both the stored word and the output
  for (genvar c = 0; c < NCOMP; c++) begin : g_widen
    pal_dac_widen #(.CW(CW), .OW(OW)) u_widen (
      .comp_i (lk_word_q[c*CW +: CW]),
      .comp_o (lk_rgb[c*OW +: OW])
    );
  end

  // R10: one-cycle result strobe
  a_r10_lat_hi: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> lk_rvalid);
  a_r10_lat_lo: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !lk_rvalid);
  // R10: result held while idle
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> $stable(lk_word_q));
endmodule

// File: rtl/pal_dac_port.sv
module pal_dac_port
  import pal_dac_pkg::*;
#(
  parameter int unsigned IW = 8,
  parameter int unsigned CW = 6,
  parameter int unsigned OW = 8,
  parameter int unsigned DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_wr,
  input  logic              hst_rd,
  input  logic [1:0]        hst_sel,
  input  logic [DW-1:0]     hst_wdata,
  output logic [DW-1:0]     hst_rdata,
  input  logic              lk_valid,
  input  logic [IW-1:0]     lk_idx,
  output logic              lk_rvalid,
  output logic [3*OW-1:0]   lk_rgb
);
  localparam int unsigned WORDW = NCOMP * CW;

  logic             ram_we;
  logic [IW-1:0]    ram_waddr, rd_idx;
  logic [WORDW-1:0] ram_wdata, rd_word;

  pal_dac_seq #(.IW(IW), .CW(CW), .DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .hst_wr    (hst_wr),
    .hst_rd    (hst_rd),
    .hst_sel   (hst_sel),
    .hst_wdata (hst_wdata),
    .hst_rdata (hst_rdata),
    .rd_word   (rd_word),
    .rd_idx    (rd_idx),
    .ram_we    (ram_we),
    .ram_waddr (ram_waddr),
    .ram_wdata (ram_wdata)
  );

  pal_dac_ram #(.IW(IW), .CW(CW), .OW(OW)) u_ram (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (ram_we),
    .waddr     (ram_waddr),
    .wdata     (ram_wdata),
    .raddr     (rd_idx),
    .rword     (rd_word),
    .lk_valid  (lk_valid),
    .lk_idx    (lk_idx),
    .lk_rvalid (lk_rvalid),
    .lk_rgb    (lk_rgb)
  );
endmodule

// File: tb/tb_pal_dac_port.sv
module tb_pal_dac_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hst_wr = 1'b0, hst_rd = 1'b0;
  logic [1:0]  hst_sel = 2'd3;
  logic [7:0]  hst_wdata = '0;
  logic [7:0]  hst_rdata;
  logic        lk_valid = 1'b0;
  logic [7:0]  lk_idx = '0;
  logic        lk_rvalid;
  logic [23:0] lk_rgb;

  int total = 0, bad = 0;

  always #2 clk = ~clk;

  pal_dac_port dut (.*);

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic hwr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk); hst_wr = 1'b1; hst_sel = sel; hst_wdata = d;
    @(negedge clk); hst_wr = 1'b0; hst_sel = 2'd3;
  endtask

  task automatic hrd(input logic [1:0] sel, output logic [7:0] d);
    @(negedge clk); hst_rd = 1'b1; hst_sel = sel;
    #1 d = hst_rdata;
    @(negedge clk); hst_rd = 1'b0; hst_sel = 2'd3;
  endtask

  task automatic look(input string req, input logic [7:0] idx, input logic [23:0] exp);
    @(negedge clk); lk_valid = 1'b1; lk_idx = idx;
    @(negedge clk); lk_valid = 1'b0;
    chk({req, " rvalid"}, 32'(lk_rvalid), 32'd1);
    chk({req, " rgb"}, 32'(lk_rgb), 32'(exp));
    @(negedge clk);
    chk("R10 rvalid drop", 32'(lk_rvalid), 32'd0);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 lk_rvalid", 32'(lk_rvalid), 32'd0);
    hrd(2'd1, d); chk("R1 write index", 32'(d), 32'h00);
    hrd(2'd0, d); chk("R1 status", 32'(d), 32'h00);
  endtask

  task automatic t_indices();
    logic [7:0] d;
    hwr(2'd0, 8'h12);
    hrd(2'd0, d); chk("R3 status after read-index load", 32'(d), 32'h03);
    hwr(2'd1, 8'h10);
    hrd(2'd1, d); chk("R2 write index readback", 32'(d), 32'h10);
    hrd(2'd0, d); chk("R2 status after write-index load", 32'(d), 32'h00);
  endtask

  task automatic t_widen();
    logic [7:0] d;
    hwr(2'd1, 8'h10);
    hwr(2'd2, 8'hFF); hwr(2'd2, 8'h01); hwr(2'd2, 8'h20);  // top bits dropped
    hrd(2'd1, d); chk("R4 write index after commit", 32'(d), 32'h11);
    look("R9 widen/R10 pack", 8'h10, 24'hFF0780);
  endtask

  task automatic t_partial();
    hwr(2'd1, 8'h20);
    hwr(2'd2, 8'h01); hwr(2'd2, 8'h02); hwr(2'd2, 8'h03);
    hwr(2'd1, 8'h20);
    hwr(2'd2, 8'h3F); hwr(2'd2, 8'h3F);
    look("R4 entry unchanged after two writes", 8'h20, 24'h07080F);
    hwr(2'd2, 8'h21);
    look("R4 commit on third write", 8'h20, 24'hFFFF87);
  endtask

  task automatic t_reload();
    hwr(2'd1, 8'h30);
    hwr(2'd2, 8'h11);
    hwr(2'd1, 8'h30);
    hwr(2'd2, 8'h05); hwr(2'd2, 8'h06); hwr(2'd2, 8'h07);
    look("R8 reload discards buffered byte", 8'h30, 24'h17181F);
  endtask

  task automatic t_stream_read();
    logic [7:0] d;
    hwr(2'd1, 8'h40);
    for (int i = 1; i <= 6; i++) hwr(2'd2, 8'(i));
    hwr(2'd0, 8'h40);
    for (int i = 1; i <= 6; i++) begin
      hrd(2'd2, d); chk($sformatf("R5 read component %0d", i), 32'(d), 32'(i));
    end
  endtask

  task automatic t_wrap();
    logic [7:0] d;
    hwr(2'd1, 8'hFF);
    hwr(2'd2, 8'h0A); hwr(2'd2, 8'h0B); hwr(2'd2, 8'h0C);
    hrd(2'd1, d); chk("R6 write index wraps", 32'(d), 32'h00);
    hwr(2'd2, 8'h0D); hwr(2'd2, 8'h0E); hwr(2'd2, 8'h0F);
    hwr(2'd0, 8'hFF);
    for (int i = 0; i < 6; i++) begin
      hrd(2'd2, d); chk("R6 read index wraps", 32'(d), 32'(8'h0A + i));
    end
  endtask

  task automatic t_shared();
    logic [7:0] d;
    hwr(2'd0, 8'h40);
    hwr(2'd1, 8'h60);
    hwr(2'd2, 8'h09);
    hrd(2'd2, d); chk("R7 read continues at counter 1", 32'(d), 32'h02);
    hrd(2'd2, d); chk("R7 read counter 2", 32'(d), 32'h03);
    hrd(2'd2, d); chk("R7 next entry after wrap of counter", 32'(d), 32'h04);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    hwr(2'd0, 8'h40);
    hwr(2'd1, 8'h70);
    @(negedge clk); hst_wr = 1'b1; hst_rd = 1'b1; hst_sel = 2'd3; hst_wdata = 8'h55;
    @(negedge clk); hst_wr = 1'b0; hst_rd = 1'b0;
    hrd(2'd3, d); chk("R11 unused select reads 0", 32'(d), 32'h00);
    hrd(2'd1, d); chk("R11 write index untouched", 32'(d), 32'h70);
    hrd(2'd2, d); chk("R11 read had no side effect", 32'(d), 32'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_indices();
    t_widen();
    t_partial();
    t_reload();
    t_stream_read();
    t_wrap();
    t_shared();
    t_collide();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule